// File: doc/BRIEF.md
# T1 Frame Alignment Search

This block finds the framing-bit position in a DS1 serial stream of 193 bits per frame. It works on superframe or extended superframe framing, picked by a mode input. No framing position is known at the start, so every bit slot inside one candidate span is a possible framing location. The candidate span is two frames in superframe mode and four frames in extended superframe mode.

Each slot keeps a 3-bit history of the bits it has seen. From that history it predicts its next bit. A slot whose bit breaks the prediction is struck out. Once every slot has been examined ten times, the search looks at how many slots survive:

- If exactly one survives, the block locks onto it. It then drives a frame pulse and a bit-in-frame index that are aligned to that slot.
- If none survive, the search starts again from scratch.
- If several survive, the search keeps going, one span at a time, until one or none is left.

Lock is held until a reframe request arrives.

Top module: `t1_frame_aligner`

## Requirements
- R1: A bit is taken only in a cycle where `bit_valid_i` is 1. A cycle with `bit_valid_i` at 0 does not change the search, the alignment or `frame_pos_o`, and it produces no frame pulse.
- R2: When `esf_mode_i` is 0 (superframe), the candidate span is 386 bits. A slot survives only while its successive bits alternate 1,0,1,0. A slot that carries the signaling framing sequence 0,0,1,1,1,0 is struck out.
- R3: When `esf_mode_i` is 1 (extended superframe), the candidate span is 772 bits. A slot survives only while its successive bits follow the repeating sequence 0,0,1,0,1,1.
- R4: Each slot's first three bits in a search only fill its 3-bit history. After that, a slot is struck out when its history is not a window of the expected sequence, or when its new bit differs from the bit that the history predicts.
- R5: No lock is declared before ten full candidate spans have been examined since the search started. Lock is declared at the end of a span in which exactly one slot survives.
- R6: If no slot survives at a decision point, a new search begins at the next span. In that search all slots are valid again, and a valid stream then locks.
- R7: If more than one slot survives at a decision point, the search continues span by span until a single survivor locks, or no survivor restarts the search.
- R8: While locked, `frame_pulse_o` is high for one cycle, in the cycle after the framing bit is taken. `frame_pos_o` is the index, from 0 to 192, of the last bit taken, counted from the framing bit, which is 0.
- R9: `lock_o` stays high until `reframe_i` is asserted. `lock_o` is low in the cycle after `reframe_i`. The next search starts at the following span boundary, using `esf_mode_i` as sampled at that start.
- R10: During and after reset, `lock_o` and `frame_pulse_o` are 0 and `frame_pos_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Received line bit |
| bit_valid_i | input | 1 | Qualifies `bit_i` for this cycle |
| esf_mode_i | input | 1 | 0 = superframe, 1 = extended superframe; sampled at search start |
| reframe_i | input | 1 | Drops lock and requests a new search |
| lock_o | output | 1 | Frame alignment found |
| frame_pulse_o | output | 1 | One-cycle pulse after each framing bit while locked |
| frame_pos_o | output | 8 | Bit index within the frame of the last bit taken, while locked |

## Verification
The properties check, on every cycle, how the frame pulse relates to the lock and to the index, that the pulse lasts one cycle, that idle cycles leave the outputs untouched, that reframe drops lock, and that lock persists otherwise. Whether the search settles on the right slot can only be shown by the bench's streams. The same holds for the ten-span minimum before a decision, for striking out a signaling or data slot, and for restarting after an all-zero stream. The bench runs both formats at several offsets and starting frames, with and without idle gaps.

// File: rtl/t1fa_pkg.sv
package t1fa_pkg;

  localparam int HIST_W = 3;

  typedef struct packed {
    logic              alive;
    logic [HIST_W-1:0] hist;   // hist[0] newest
  } cand_t;

  typedef enum logic [1:0] {
    ST_WAIT,
    ST_SEARCH,
    ST_LOCK
  } aln_state_e;

  // returns {window_known, predicted_bit}
  function automatic logic [1:0] predict_next(input logic esf, input logic [HIST_W-1:0] h);
    logic [1:0] r;
    r = 2'b00;
    if (!esf) begin
      unique case (h)
        3'b010:  r = 2'b11;
        3'b101:  r = 2'b10;
        default: r = 2'b00;
      endcase
    end else begin
      unique case (h)
        3'b001:  r = 2'b10;
        3'b010:  r = 2'b11;
        3'b101:  r = 2'b11;
        3'b011:  r = 2'b10;
        3'b110:  r = 2'b10;
        3'b100:  r = 2'b11;
        default: r = 2'b00;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/t1fa_bit_timer.sv
module t1fa_bit_timer #(
  parameter int FRAME_BITS = 193,
  parameter int DEPTH      = 772,
  localparam int AW        = $clog2(DEPTH),
  localparam int PHW       = $clog2(FRAME_BITS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           adv_i,
  input  logic [AW-1:0]  last_i,
  output logic [AW-1:0]  slot_o,
  output logic [PHW-1:0] phase_o,
  output logic           wrap_o
);

  localparam logic [PHW-1:0] PH_LAST = PHW'(FRAME_BITS - 1);

  logic [AW-1:0]  slot_q;
  logic [PHW-1:0] phase_q;

  assign wrap_o  = (slot_q >= last_i);
  assign slot_o  = slot_q;
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= '0;
      phase_q <= '0;
    end else if (adv_i) begin
      slot_q  <= wrap_o ? '0 : slot_q + AW'(1);
      phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + PHW'(1);
    end
  end

endmodule

// File: rtl/t1fa_hist_mem.sv
module t1fa_hist_mem
  import t1fa_pkg::*;
#(
  parameter int DEPTH = 772,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  cand_t         wdata_i,
  output cand_t         rdata_o
);

  cand_t mem_q [DEPTH];

  assign rdata_o = (int'(addr_i) < DEPTH) ? mem_q[addr_i] : '0;

  always_ff @(posedge clk_i) begin
    if (we_i && (int'(addr_i) < DEPTH)) mem_q[addr_i] <= wdata_i;
  end

endmodule

// File: rtl/t1fa_cand_eval.sv
module t1fa_cand_eval
  import t1fa_pkg::*;
(
  input  logic  first_i,
  input  logic  check_i,
  input  logic  esf_i,
  input  logic  bit_i,
  input  cand_t cur_i,
  output cand_t nxt_o,
  output logic  keep_o
);

  logic [1:0] pr;
  logic       hit;

  assign pr  = predict_next(esf_i, cur_i.hist);
  assign hit = pr[1] && (pr[0] == bit_i);

  always_comb begin
    if (first_i) begin
      nxt_o.alive = 1'b1;
      nxt_o.hist  = {{(HIST_W-1){1'b0}}, bit_i};
    end else begin
      nxt_o.alive = cur_i.alive && (!check_i || hit);
      nxt_o.hist  = {cur_i.hist[HIST_W-2:0], bit_i};
    end
  end

  assign keep_o = nxt_o.alive;

endmodule

// File: rtl/t1_frame_aligner.sv
module t1_frame_aligner
  import t1fa_pkg::*;
#(
  parameter int FRAME_BITS  = 193,
  parameter int SF_FRAMES   = 2,
  parameter int ESF_FRAMES  = 4,
  parameter int DECIDE_BITS = 10
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          bit_i,
  input  logic                          bit_valid_i,
  input  logic                          esf_mode_i,
  input  logic                          reframe_i,
  output logic                          lock_o,
  output logic                          frame_pulse_o,
  output logic [$clog2(FRAME_BITS)-1:0] frame_pos_o
);

  localparam int DEPTH = FRAME_BITS * ESF_FRAMES;
  localparam int AW    = $clog2(DEPTH);
  localparam int PHW   = $clog2(FRAME_BITS);
  localparam int PW    = $clog2(DECIDE_BITS + 1);
  localparam logic [AW-1:0]  SF_LAST  = AW'(FRAME_BITS * SF_FRAMES - 1);
  localparam logic [AW-1:0]  ESF_LAST = AW'(DEPTH - 1);
  localparam logic [PW-1:0]  PASS_CHK = PW'(HIST_W);
  localparam logic [PW-1:0]  PASS_DEC = PW'(DECIDE_BITS - 1);
  localparam logic [PHW-1:0] FB       = PHW'(FRAME_BITS);

  aln_state_e     st_q;
  logic           mode_q;
  logic [PW-1:0]  pass_q;
  logic [1:0]     surv_q;
  logic [PHW-1:0] surv_ph_q;
  logic [PHW-1:0] lock_ph_q;
  logic           pulse_q;
  logic [PHW-1:0] fpos_q;

  logic [AW-1:0]  slot;
  logic [PHW-1:0] phase;
  logic           wrap;
  logic           start_now, active, mode_eff, take;
  logic [AW-1:0]  last_slot;
  logic [PW-1:0]  pass_eff;
  logic           first_pass, check_pass, decide;
  cand_t          cur, nxt;
  logic           keep;
  logic [1:0]     surv_base, surv_nxt;
  logic [PHW-1:0] ph_nxt, fpos_nxt;

  assign start_now  = (st_q == ST_WAIT) && (slot == '0);
  assign active     = (st_q == ST_SEARCH) || start_now;
  assign mode_eff   = start_now ? esf_mode_i : mode_q;
  assign last_slot  = mode_eff ? ESF_LAST : SF_LAST;
  assign pass_eff   = start_now ? '0 : pass_q;
  assign first_pass = (pass_eff == '0);
  assign check_pass = (pass_eff >= PASS_CHK);
  assign take       = active && bit_valid_i && !reframe_i;
  assign decide     = take && wrap && (pass_eff >= PASS_DEC);

  t1fa_bit_timer #(
    .FRAME_BITS(FRAME_BITS),
    .DEPTH     (DEPTH)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (bit_valid_i),
    .last_i (last_slot),
    .slot_o (slot),
    .phase_o(phase),
    .wrap_o (wrap)
  );

  t1fa_hist_mem #(
    .DEPTH(DEPTH)
  ) u_mem (
    .clk_i  (clk_i),
    .we_i   (take),
    .addr_i (slot),
    .wdata_i(nxt),
    .rdata_o(cur)
  );

  t1fa_cand_eval u_eval (
    .first_i(first_pass),
    .check_i(check_pass),
    .esf_i  (mode_eff),
    .bit_i  (bit_i),
    .cur_i  (cur),
    .nxt_o  (nxt),
    .keep_o (keep)
  );

  // survivor tally saturates at 2: only none / one / many matter
  assign surv_base = (slot == '0) ? 2'd0 : surv_q;
  assign surv_nxt  = (surv_base == 2'd2) ? 2'd2 : surv_base + {1'b0, keep};
  assign ph_nxt    = keep ? phase : surv_ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_WAIT;
      mode_q    <= 1'b0;
      pass_q    <= '0;
      surv_q    <= '0;
      surv_ph_q <= '0;
      lock_ph_q <= '0;
    end else if (reframe_i) begin
      st_q <= ST_WAIT;
    end else begin
      if (start_now) begin
        st_q   <= ST_SEARCH;
        mode_q <= esf_mode_i;
        pass_q <= '0;
      end
      if (take) begin
        surv_q    <= surv_nxt;
        surv_ph_q <= ph_nxt;
        if (wrap) begin
          if (!decide) begin
            pass_q <= pass_eff + PW'(1);
          end else if (surv_nxt == 2'd0) begin
            pass_q <= '0;
            mode_q <= esf_mode_i;
          end else if (surv_nxt == 2'd1) begin
            st_q      <= ST_LOCK;
            lock_ph_q <= ph_nxt;
          end
        end
      end
    end
  end

  assign fpos_nxt = (phase >= lock_ph_q) ? phase - lock_ph_q
                                         : FB + phase - lock_ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      fpos_q  <= '0;
    end else if (reframe_i) begin
      pulse_q <= 1'b0;
      fpos_q  <= '0;
    end else begin
      pulse_q <= 1'b0;
      if ((st_q == ST_LOCK) && bit_valid_i) begin
        pulse_q <= (phase == lock_ph_q);
        fpos_q  <= fpos_nxt;
      end
    end
  end

  assign lock_o        = (st_q == ST_LOCK);
  assign frame_pulse_o = pulse_q;
  assign frame_pos_o   = fpos_q;

endmodule

// File: rtl/t1fa_chk.sv
module t1fa_chk #(
  parameter int FRAME_BITS = 193,
  localparam int PHW       = $clog2(FRAME_BITS)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           bit_valid_i,
  input logic           reframe_i,
  input logic           lock_o,
  input logic           frame_pulse_o,
  input logic [PHW-1:0] frame_pos_o
);

  assert_pulse_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_pulse_o |-> lock_o);

  assert_pulse_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_pulse_o |=> !frame_pulse_o);

  assert_pulse_pos_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_pulse_o |-> (frame_pos_o == '0));

  assert_pos_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_pos_o < PHW'(FRAME_BITS));

  assert_idle_no_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_i |=> !frame_pulse_o);

  assert_idle_pos_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_valid_i && !reframe_i) |=> $stable(frame_pos_o));

  assert_lock_on_bit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(bit_valid_i));

  assert_reframe_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reframe_i |=> !lock_o);

  assert_lock_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !reframe_i) |=> lock_o);

endmodule

bind t1_frame_aligner t1fa_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bit_valid_i  (bit_valid_i),
  .reframe_i    (reframe_i),
  .lock_o       (lock_o),
  .frame_pulse_o(frame_pulse_o),
  .frame_pos_o  (frame_pos_o)
);

// File: tb/sim_t1_frame_aligner.sv
module sim_t1_frame_aligner;

  localparam int FB  = 193;
  localparam int NSC = 4;
  localparam bit SC_ESF   [NSC] = '{1'b0, 1'b1, 1'b0, 1'b1};
  localparam int SC_OFF   [NSC] = '{0, 57, 192, 130};
  localparam int SC_START [NSC] = '{0, 5, 3, 22};
  localparam bit SC_GAP   [NSC] = '{1'b0, 1'b0, 1'b1, 1'b1};
  localparam bit FS_SEQ  [6] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam bit FPS_SEQ [6] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_i = 1'b0;
  logic       bit_valid_i = 1'b0;
  logic       esf_mode_i = 1'b0;
  logic       reframe_i = 1'b0;
  logic       lock_o;
  logic       frame_pulse_o;
  logic [7:0] frame_pos_o;

  int   nchk = 0;
  int   nfail = 0;
  bit   done = 1'b0;
  logic [30:0] lfsr = 31'h1234_5679;
  int   idx;
  bit   cur_esf;
  int   cur_off, cur_start;

  always #2 clk_i = ~clk_i;

  t1_frame_aligner u0 (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_i        (bit_i),
    .bit_valid_i  (bit_valid_i),
    .esf_mode_i   (esf_mode_i),
    .reframe_i    (reframe_i),
    .lock_o       (lock_o),
    .frame_pulse_o(frame_pulse_o),
    .frame_pos_o  (frame_pos_o)
  );

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic step(input logic v, input logic b);
    bit_valid_i = v;
    bit_i       = b;
    @(posedge clk_i);
    @(negedge clk_i);
    bit_valid_i = 1'b0;
  endtask

  task automatic next_bit(output logic b);
    int f, p;
    f = cur_start + idx / FB;
    p = idx % FB;
    lfsr = {lfsr[29:0], lfsr[30] ^ lfsr[27]};
    b = lfsr[0];
    if (p == cur_off) begin
      if (!cur_esf) begin
        if (f % 2 == 0) b = ((f / 2) % 2 == 0);
        else            b = FS_SEQ[(f / 2) % 6];
      end else if (f % 4 == 3) begin
        b = FPS_SEQ[(f / 4) % 6];
      end
    end
  endtask

  task automatic run_until_lock(input int limit, input bit gaps, output int bits);
    logic b;
    bits = 0;
    while (!lock_o && bits < limit) begin
      next_bit(b);
      step(1'b1, b);
      idx++;
      bits++;
      if (gaps && (bits % 7 == 0)) step(1'b0, 1'b0);
    end
  endtask

  // checks pulse and index on each taken bit, and quiet idle cycles
  task automatic verify_aligned(input int nbits, input bit gaps, input string req);
    logic b;
    int   p;
    logic [7:0] held;
    for (int k = 0; k < nbits; k++) begin
      next_bit(b);
      p = idx % FB;
      step(1'b1, b);
      idx++;
      check(req, int'(frame_pulse_o), int'(p == cur_off));
      check(req, int'(frame_pos_o), (p + FB - cur_off) % FB);
      if (gaps && (k % 5 == 2)) begin
        held = frame_pos_o;
        step(1'b0, 1'b0);
        check("R1 idle pulse", int'(frame_pulse_o), 0);
        check("R1 idle pos", int'(frame_pos_o), int'(held));
      end
    end
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int  bits;
    int  span;
    bit  seen;
    logic b;

    repeat (3) @(negedge clk_i);
    // R10: reset state
    check("R10 lock", int'(lock_o), 0);
    check("R10 pulse", int'(frame_pulse_o), 0);
    check("R10 pos", int'(frame_pos_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int s = 0; s < NSC; s++) begin
      cur_esf    = SC_ESF[s];
      cur_off    = SC_OFF[s];
      cur_start  = SC_START[s];
      esf_mode_i = cur_esf;
      idx        = 0;
      span       = cur_esf ? 4 * FB : 2 * FB;
      if (s != 0) begin
        reframe_i = 1'b1;
        step(1'b0, 1'b0);
        reframe_i = 1'b0;
        check("R9 reframe drop", int'(lock_o), 0);
      end
      run_until_lock(40 * span, SC_GAP[s], bits);
      // R2 superframe / R3 extended superframe / R7 several survivors resolved
      check(cur_esf ? "R3 R7 lock" : "R2 R7 lock", int'(lock_o), 1);
      // R5: no decision before ten spans
      check("R5 min spans", int'(bits >= 10 * span), 1);
      verify_aligned(3 * FB, SC_GAP[s], cur_esf ? "R8 R3 align" : "R8 R2 align");
    end

    // R9: lock held with corrupted framing bits
    for (int k = 0; k < 4 * FB; k++) step(1'b1, 1'b1);
    check("R9 lock held", int'(lock_o), 1);

    // R4 R6: all-zero stream never locks, then a valid stream locks
    esf_mode_i = 1'b0;
    reframe_i  = 1'b1;
    step(1'b0, 1'b0);
    reframe_i  = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 25 * 2 * FB; k++) begin
      step(1'b1, 1'b0);
      if (lock_o) seen = 1'b1;
    end
    check("R4 R6 zero stream no lock", int'(seen), 0);
    cur_esf   = 1'b0;
    cur_off   = 77;
    cur_start = 1;
    idx       = 0;
    run_until_lock(40 * 2 * FB, 1'b0, bits);
    check("R6 relock after restart", int'(lock_o), 1);
    verify_aligned(2 * FB, 1'b0, "R6 R8 align");

    // R10: reset while locked
    rst_ni = 1'b0;
    step(1'b1, 1'b1);
    check("R10 lock after reset", int'(lock_o), 0);
    check("R10 pulse after reset", int'(frame_pulse_o), 0);
    check("R10 pos after reset", int'(frame_pos_o), 0);
    rst_ni = 1'b1;
    next_bit(b);
    step(1'b0, b);
    check("R10 idle after reset", int'(lock_o), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule